// File: doc/BRIEF.md
# Configurable UART Frame Engine

This block is the serial core of a UART port. It moves characters between a pair of byte-wide FIFOs and the TX and RX lines. Its timebase is a single-cycle strobe that pulses eight times per bit period. The frame format comes from a 32-bit control word: port enable, 7 or 8 data bits, one or two transmit stop bits, optional parity with four modes, hardware flow control and internal loopback. The register file that holds the control word, the FIFO storage and the strobe generator all live outside the block.

The transmitter pops one byte from the TX FIFO at a strobe between frames and shifts the frame out LSB first. With flow control on, a frame does not start while CTS is low. The receiver validates a start edge at mid-bit and samples every later bit at its midpoint. It then pushes the character into the RX FIFO. Parity errors, framing errors, breaks and overflows are reported as separate one-cycle pulses. RTS follows the RX fill level, compared against a separate auto-flow level.

Top module: `uart_frame_engine`

## Requirements
- R1: After reset the TX line is high, and tx_pop_o, rx_push_o and all four error pulses are low.
- R2: A transmitted frame has a low start bit, then the data bits LSB first, then an optional parity bit, then a high stop bit. Each bit lasts 8 strobes. ctrl_i[1]=1 selects 8 data bits and ctrl_i[1]=0 selects 7 data bits (byte bit 7 is not sent).
- R3: ctrl_i[3]=1 adds a parity bit after the data. ctrl_i[5:4] picks the mode: 0 gives odd, 1 gives even, 2 gives a constant 0 and 3 gives a constant 1.
- R4: ctrl_i[2]=1 makes the transmitter send two stop bits. With a byte waiting, consecutive 8-bit no-parity frames then start 89 strobes apart instead of 81.
- R5: With ctrl_i[23]=1, no frame starts and nothing is popped while cts_i is low. rts_o is high when ctrl_i[23]=0; otherwise rts_o is high exactly when rx_level_i < afc_level_i.
- R6: With ctrl_i[0]=0 the transmitter pops nothing and keeps the line high, and the receiver pushes nothing. A byte left waiting is sent once the port is enabled.
- R7: With ctrl_i[24]=1, uart_tx_o stays high and the transmitted frame is received internally.
- R8: A low pulse on the RX line that is gone by the 4th strobe after the start edge is detected produces no character.
- R9: A received character is pushed with its data bits LSB first. In 7-bit mode rx_data_o[7] is 0.
- R10: With parity on, parity_err_o pulses together with the push when the received parity bit differs from the selected mode.
- R11: framing_err_o pulses when the first stop-bit sample is 0.
- R12: break_o pulses, together with framing_err_o, when data, parity and stop samples are all 0. The receiver then waits for the line to go high before it looks for a new start, so a long break yields one character.
- R13: If rx_full_i is high when a character completes, overflow_o pulses and the character is not pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Strobe at 8x the baud rate |
| ctrl_i | input | 32 | Control word (frame format, flow control, loopback) |
| tx_valid_i | input | 1 | TX FIFO holds a byte |
| tx_data_i | input | 8 | Byte at the TX FIFO head |
| tx_pop_o | output | 1 | Pop the TX FIFO head |
| rx_push_o | output | 1 | Push rx_data_o into the RX FIFO |
| rx_data_o | output | 8 | Received character |
| rx_full_i | input | 1 | RX FIFO is full |
| rx_level_i | input | LVL_W | RX FIFO fill level |
| afc_level_i | input | LVL_W | Auto-flow RTS threshold |
| cts_i | input | 1 | Clear to send, high when asserted |
| rts_o | output | 1 | Request to send, high when asserted |
| uart_rx_i | input | 1 | Serial receive line |
| uart_tx_o | output | 1 | Serial transmit line |
| parity_err_o | output | 1 | Parity error pulse |
| framing_err_o | output | 1 | Framing error pulse |
| break_o | output | 1 | Break pulse |
| overflow_o | output | 1 | Overflow pulse |

## Verification
The transmitter is exercised with 8-bit and 7-bit data and with all four parity modes on a byte of odd weight. Because that byte has odd weight, the odd and even results differ, and so do the two constant modes. Start-to-start spacing of back-to-back frames is measured in clock cycles, which separates one stop bit from two. The receiver is fed clean frames, frames with a wrong parity bit, frames with a zero stop bit, a long low break and a short glitch. Each of these is told apart by which pulse fires and how many pushes follow. Enable, CTS hold-off, loopback and a full RX FIFO are checked by counting pops and pushes and by watching that the TX pin stays high.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;

  // control-word bit positions decoded by the register file
  localparam int unsigned CTL_EN      = 0;
  localparam int unsigned CTL_D8      = 1;
  localparam int unsigned CTL_STOP2   = 2;
  localparam int unsigned CTL_PAR_EN  = 3;
  localparam int unsigned CTL_PAR_LSB = 4;
  localparam int unsigned CTL_FLOW    = 23;
  localparam int unsigned CTL_LOOP    = 24;

  typedef enum logic [1:0] {
    PAR_ODD   = 2'd0,
    PAR_EVEN  = 2'd1,
    PAR_SPACE = 2'd2,
    PAR_MARK  = 2'd3
  } par_mode_e;

  typedef struct packed {
    logic      en;
    logic      d8;
    logic      stop2;
    logic      par_en;
    par_mode_e par_mode;
    logic      flow_en;
    logic      loop_en;
  } frame_cfg_t;

  function automatic frame_cfg_t decode_ctrl(input logic [31:0] c);
    frame_cfg_t f;
    f.en       = c[CTL_EN];
    f.d8       = c[CTL_D8];
    f.stop2    = c[CTL_STOP2];
    f.par_en   = c[CTL_PAR_EN];
    f.par_mode = par_mode_e'(c[CTL_PAR_LSB +: 2]);
    f.flow_en  = c[CTL_FLOW];
    f.loop_en  = c[CTL_LOOP];
    return f;
  endfunction

  function automatic logic par_bit(input par_mode_e m, input logic [7:0] d, input logic d8);
    logic x;
    x = ^(d & {d8, 7'h7f});
    case (m)
      PAR_ODD:   return ~x;
      PAR_EVEN:  return x;
      PAR_SPACE: return 1'b0;
      default:   return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/uart_fe_tx.sv
module uart_fe_tx
  import uart_fe_pkg::*;
#(
  parameter int unsigned OVS = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       en_i,
  input  logic       d8_i,
  input  logic       stop2_i,
  input  logic       par_en_i,
  input  par_mode_e  par_mode_i,
  input  logic       flow_en_i,
  input  logic       cts_i,
  input  logic       tx_valid_i,
  input  logic [7:0] tx_data_i,
  output logic       tx_pop_o,
  output logic       line_o
);
  localparam int unsigned CW = $clog2(OVS);

  typedef enum logic [2:0] {TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP} tx_st_e;

  tx_st_e        st;
  logic [CW-1:0] tcnt;
  logic [7:0]    shreg;
  logic [2:0]    bidx;
  logic          pbit, stop_second;
  logic          bit_end;

  assign bit_end  = tick_i && (tcnt == CW'(OVS - 1));
  assign tx_pop_o = en_i && tick_i && (st == TX_IDLE) && tx_valid_i && (!flow_en_i || cts_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st          <= TX_IDLE;
      tcnt        <= '0;
      shreg       <= '0;
      bidx        <= '0;
      pbit        <= 1'b0;
      stop_second <= 1'b0;
    end else if (!en_i) begin
      st   <= TX_IDLE;
      tcnt <= '0;
    end else begin
      if (st != TX_IDLE && tick_i) tcnt <= bit_end ? '0 : tcnt + 1'b1;
      case (st)
        TX_IDLE: if (tx_pop_o) begin
          shreg       <= tx_data_i;
          pbit        <= par_bit(par_mode_i, tx_data_i, d8_i);
          bidx        <= '0;
          stop_second <= 1'b0;
          tcnt        <= '0;
          st          <= TX_START;
        end
        TX_START: if (bit_end) st <= TX_DATA;
        TX_DATA: if (bit_end) begin
          shreg <= shreg >> 1;
          bidx  <= bidx + 1'b1;
          if (bidx == (d8_i ? 3'd7 : 3'd6)) st <= par_en_i ? TX_PAR : TX_STOP;
        end
        TX_PAR: if (bit_end) st <= TX_STOP;
        TX_STOP: if (bit_end) begin
          if (stop2_i && !stop_second) stop_second <= 1'b1;
          else st <= TX_IDLE;
        end
        default: st <= TX_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st)
      TX_START: line_o = 1'b0;
      TX_DATA:  line_o = shreg[0];
      TX_PAR:   line_o = pbit;
      default:  line_o = 1'b1;
    endcase
  end

  // R2
  tx_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pop_o |=> (st == TX_START && !line_o));

  // R5
  flow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flow_en_i && !cts_i && st == TX_IDLE) |=> (st == TX_IDLE));

endmodule

// File: rtl/uart_fe_rx.sv
module uart_fe_rx
  import uart_fe_pkg::*;
#(
  parameter int unsigned OVS = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       en_i,
  input  logic       d8_i,
  input  logic       par_en_i,
  input  par_mode_e  par_mode_i,
  input  logic       rx_i,
  input  logic       rx_full_i,
  output logic       push_o,
  output logic [7:0] data_o,
  output logic       par_err_o,
  output logic       frm_err_o,
  output logic       brk_o,
  output logic       ovf_o
);
  localparam int unsigned CW = $clog2(OVS);

  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_HOLD} rx_st_e;

  rx_st_e        st;
  logic [CW-1:0] tcnt;
  logic [7:0]    shreg, aligned;
  logic [2:0]    bidx;
  logic          rpar, any_one;
  logic          samp, mid;

  assign samp    = tick_i && (tcnt == CW'(OVS - 1));
  assign mid     = tick_i && (tcnt == CW'(OVS / 2 - 1));
  assign aligned = d8_i ? shreg : {1'b0, shreg[7:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st        <= RX_IDLE;
      tcnt      <= '0;
      shreg     <= '0;
      bidx      <= '0;
      rpar      <= 1'b0;
      any_one   <= 1'b0;
      push_o    <= 1'b0;
      data_o    <= '0;
      par_err_o <= 1'b0;
      frm_err_o <= 1'b0;
      brk_o     <= 1'b0;
      ovf_o     <= 1'b0;
    end else begin
      push_o    <= 1'b0;
      par_err_o <= 1'b0;
      frm_err_o <= 1'b0;
      brk_o     <= 1'b0;
      ovf_o     <= 1'b0;
      if (!en_i) begin
        st   <= RX_IDLE;
        tcnt <= '0;
      end else begin
        if (st != RX_IDLE && st != RX_HOLD && tick_i) tcnt <= samp ? '0 : tcnt + 1'b1;
        case (st)
          RX_IDLE: if (tick_i && !rx_i) begin
            st      <= RX_START;
            tcnt    <= '0;
            bidx    <= '0;
            any_one <= 1'b0;
          end
          RX_START: if (mid) begin
            tcnt <= '0;
            st   <= rx_i ? RX_IDLE : RX_DATA;
          end
          RX_DATA: if (samp) begin
            shreg   <= {rx_i, shreg[7:1]};
            any_one <= any_one | rx_i;
            bidx    <= bidx + 1'b1;
            if (bidx == (d8_i ? 3'd7 : 3'd6)) st <= par_en_i ? RX_PAR : RX_STOP;
          end
          RX_PAR: if (samp) begin
            rpar    <= rx_i;
            any_one <= any_one | rx_i;
            st      <= RX_STOP;
          end
          RX_STOP: if (samp) begin
            data_o    <= aligned;
            push_o    <= !rx_full_i;
            ovf_o     <= rx_full_i;
            frm_err_o <= !rx_i;
            brk_o     <= !rx_i && !any_one;
            par_err_o <= par_en_i && (rpar != par_bit(par_mode_i, aligned, d8_i));
            st        <= rx_i ? RX_IDLE : RX_HOLD;
          end
          RX_HOLD: if (rx_i) st <= RX_IDLE;
          default: st <= RX_IDLE;
        endcase
      end
    end
  end

  // R13
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> !push_o);

  // R12
  break_framing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_o |-> frm_err_o);

  // R8
  glitch_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && st == RX_START && mid && rx_i) |=> (st == RX_IDLE));

endmodule

// File: rtl/uart_frame_engine.sv
module uart_frame_engine
  import uart_fe_pkg::*;
#(
  parameter int unsigned OVS         = 8,
  parameter int unsigned LVL_W       = 7,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [31:0]      ctrl_i,
  input  logic             tx_valid_i,
  input  logic [7:0]       tx_data_i,
  output logic             tx_pop_o,
  output logic             rx_push_o,
  output logic [7:0]       rx_data_o,
  input  logic             rx_full_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic [LVL_W-1:0] afc_level_i,
  input  logic             cts_i,
  output logic             rts_o,
  input  logic             uart_rx_i,
  output logic             uart_tx_o,
  output logic             parity_err_o,
  output logic             framing_err_o,
  output logic             break_o,
  output logic             overflow_o
);
  frame_cfg_t       cfg;
  logic             tx_line, rx_line;
  logic [SYNC_STAGES-1:0] sync_q;

  assign cfg = decode_ctrl(ctrl_i);

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[i] <= 1'b1;
        else         sync_q[i] <= (i == 0) ? uart_rx_i : sync_q[(i == 0) ? 0 : i - 1];
      end
    end
  endgenerate

  assign rx_line   = cfg.loop_en ? tx_line : sync_q[SYNC_STAGES-1];
  assign uart_tx_o = cfg.loop_en ? 1'b1 : tx_line;
  assign rts_o     = !cfg.flow_en || (rx_level_i < afc_level_i);

  uart_fe_tx #(.OVS(OVS)) i_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .en_i       (cfg.en),
    .d8_i       (cfg.d8),
    .stop2_i    (cfg.stop2),
    .par_en_i   (cfg.par_en),
    .par_mode_i (cfg.par_mode),
    .flow_en_i  (cfg.flow_en),
    .cts_i      (cts_i),
    .tx_valid_i (tx_valid_i),
    .tx_data_i  (tx_data_i),
    .tx_pop_o   (tx_pop_o),
    .line_o     (tx_line)
  );

  uart_fe_rx #(.OVS(OVS)) i_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .en_i       (cfg.en),
    .d8_i       (cfg.d8),
    .par_en_i   (cfg.par_en),
    .par_mode_i (cfg.par_mode),
    .rx_i       (rx_line),
    .rx_full_i  (rx_full_i),
    .push_o     (rx_push_o),
    .data_o     (rx_data_o),
    .par_err_o  (parity_err_o),
    .frm_err_o  (framing_err_o),
    .brk_o      (break_o),
    .ovf_o      (overflow_o)
  );

  // R7
  loop_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.loop_en && $stable(ctrl_i)) |=> uart_tx_o);

endmodule

// File: tb/test_uart_frame_engine.sv
`timescale 1ns/1ps
module test_uart_frame_engine;
  localparam int C_EN = 1, C_D8 = 2, C_S2 = 4, C_PE = 8;
  localparam int C_FLOW = 1 << 23, C_LOOP = 1 << 24;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic [31:0] ctrl = '0;
  logic tx_valid, tx_pop, rx_push, rx_full = 1'b0, cts = 1'b1, rts;
  logic [7:0] tx_data, rx_data;
  logic [6:0] rx_level = '0, afc_level = 7'd20;
  logic uart_rx = 1'b1, uart_tx, perr, ferr, brk, ovf;

  int checks = 0, errors = 0;
  int tick_cnt = 0;
  logic [7:0] tx_q [8];
  int tx_wr = 0, tx_rd = 0;
  int n_push = 0, n_perr = 0, n_ferr = 0, n_brk = 0, n_ovf = 0, n_txlow = 0;
  logic [7:0] last_data = '0;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    tick_cnt <= (tick_cnt == 3) ? 0 : tick_cnt + 1;
    tick     <= (tick_cnt == 3);
    if (tx_pop) tx_rd <= tx_rd + 1;
  end

  assign tx_valid = (tx_rd != tx_wr);
  assign tx_data  = tx_q[tx_rd % 8];

  always @(negedge clk) begin
    if (rx_push) begin n_push++; last_data = rx_data; end
    if (perr) n_perr++;
    if (ferr) n_ferr++;
    if (brk)  n_brk++;
    if (ovf)  n_ovf++;
    if (rst_n && !uart_tx) n_txlow++;
  end

  uart_frame_engine i_uart_frame_engine (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .ctrl_i(ctrl),
    .tx_valid_i(tx_valid), .tx_data_i(tx_data), .tx_pop_o(tx_pop),
    .rx_push_o(rx_push), .rx_data_o(rx_data), .rx_full_i(rx_full),
    .rx_level_i(rx_level), .afc_level_i(afc_level), .cts_i(cts), .rts_o(rts),
    .uart_rx_i(uart_rx), .uart_tx_o(uart_tx),
    .parity_err_o(perr), .framing_err_o(ferr), .break_o(brk), .overflow_o(ovf)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push_tx(input logic [7:0] d);
    tx_q[tx_wr % 8] = d;
    tx_wr++;
  endtask

  task automatic get_tx(input int nb, input bit hp, output int d, output int p, output int s);
    int t = 0;
    d = 0; p = 0; s = 0;
    while (uart_tx !== 1'b0 && t < 4000) begin @(negedge clk); t++; end
    chk(t < 4000, "R2 start seen", t, 0);
    repeat (16) @(negedge clk);
    chk(uart_tx == 1'b0, "R2 start bit", int'(uart_tx), 0);
    for (int i = 0; i < nb; i++) begin
      repeat (32) @(negedge clk);
      d |= int'(uart_tx) << i;
    end
    if (hp) begin repeat (32) @(negedge clk); p = int'(uart_tx); end
    repeat (32) @(negedge clk);
    s = int'(uart_tx);
  endtask

  task automatic send_rx(input int d, input int nb, input bit hp, input bit p, input bit stp);
    uart_rx = 1'b0; repeat (32) @(negedge clk);
    for (int i = 0; i < nb; i++) begin uart_rx = d[i]; repeat (32) @(negedge clk); end
    if (hp) begin uart_rx = p; repeat (32) @(negedge clk); end
    uart_rx = stp; repeat (32) @(negedge clk);
    uart_rx = 1'b1; repeat (64) @(negedge clk);
  endtask

  task automatic settle();
    int t = 0;
    while (tx_rd != tx_wr && t < 4000) begin @(negedge clk); t++; end
    repeat (400) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(uart_tx == 1'b1, "R1 tx idle", int'(uart_tx), 1);
    chk(!tx_pop && !rx_push, "R1 no pop/push", int'({tx_pop, rx_push}), 0);
    chk(!perr && !ferr && !brk && !ovf, "R1 pulses low", int'({perr, ferr, brk, ovf}), 0);
  endtask

  task automatic t_tx_basic();
    int d, p, s;
    ctrl = C_EN | C_D8;
    push_tx(8'hA5);
    get_tx(8, 0, d, p, s);
    chk(d == 'hA5, "R2 8-bit data", d, 'hA5);
    chk(s == 1, "R2 stop bit", s, 1);
    settle();
    ctrl = C_EN;
    push_tx(8'hD3);
    get_tx(7, 0, d, p, s);
    chk(d == 'h53, "R2 7-bit data", d, 'h53);
    chk(s == 1, "R2 7-bit stop", s, 1);
    settle();
  endtask

  task automatic t_tx_parity();
    int d, p, s;
    int exp_p [4] = '{0, 1, 0, 1};
    for (int m = 0; m < 4; m++) begin
      ctrl = C_EN | C_D8 | C_PE | (m << 4);
      push_tx(8'h5B);
      get_tx(8, 1, d, p, s);
      chk(p == exp_p[m], "R3 parity mode", p, exp_p[m]);
      chk(d == 'h5B && s == 1, "R3 data/stop with parity", d, 'h5B);
      settle();
    end
  endtask

  task automatic measure_gap(input int c, output int gap);
    int t = 0;
    ctrl = c;
    push_tx(8'hFF); push_tx(8'hFF);
    while (uart_tx !== 1'b0 && t < 4000) begin @(negedge clk); t++; end
    gap = 0;
    while (uart_tx === 1'b0 && gap < 4000) begin @(negedge clk); gap++; end
    while (uart_tx !== 1'b0 && gap < 4000) begin @(negedge clk); gap++; end
    settle();
  endtask

  task automatic t_stop2();
    int g;
    measure_gap(C_EN | C_D8, g);
    chk(g == 324, "R4 one stop spacing", g, 324);
    measure_gap(C_EN | C_D8 | C_S2, g);
    chk(g == 356, "R4 two stop spacing", g, 356);
  endtask

  task automatic t_flow();
    int d, p, s, low0;
    ctrl = C_EN | C_D8 | C_FLOW;
    cts = 1'b0;
    low0 = n_txlow;
    push_tx(8'h6E);
    repeat (500) @(negedge clk);
    chk(tx_rd == tx_wr - 1, "R5 no pop while CTS low", tx_rd, tx_wr - 1);
    chk(n_txlow == low0, "R5 line held high", n_txlow - low0, 0);
    cts = 1'b1;
    get_tx(8, 0, d, p, s);
    chk(d == 'h6E, "R5 sent after CTS", d, 'h6E);
    settle();
    rx_level = 7'd5;  #1;
    chk(rts == 1'b1, "R5 rts below level", int'(rts), 1);
    rx_level = 7'd20; #1;
    chk(rts == 1'b0, "R5 rts at level", int'(rts), 0);
    ctrl = C_EN | C_D8; #1;
    chk(rts == 1'b1, "R5 rts flow off", int'(rts), 1);
    rx_level = 7'd0;
  endtask

  task automatic t_enable();
    int d, p, s, pu0;
    ctrl = C_D8;
    push_tx(8'h12);
    repeat (500) @(negedge clk);
    chk(tx_rd == tx_wr - 1, "R6 no pop disabled", tx_rd, tx_wr - 1);
    chk(uart_tx == 1'b1, "R6 line high disabled", int'(uart_tx), 1);
    pu0 = n_push;
    send_rx('h34, 8, 0, 0, 1);
    chk(n_push == pu0, "R6 no push disabled", n_push - pu0, 0);
    ctrl = C_EN | C_D8;
    get_tx(8, 0, d, p, s);
    chk(d == 'h12, "R6 waiting byte sent", d, 'h12);
    settle();
  endtask

  task automatic t_loop();
    int t = 0, low0, pu0;
    ctrl = C_EN | C_D8 | C_LOOP;
    repeat (4) @(negedge clk);
    low0 = n_txlow; pu0 = n_push;
    push_tx(8'h3C);
    while (n_push == pu0 && t < 4000) begin @(negedge clk); t++; end
    repeat (100) @(negedge clk);
    chk(n_txlow == low0, "R7 pin stays high", n_txlow - low0, 0);
    chk(n_push == pu0 + 1 && last_data == 8'h3C, "R7 looped data", int'(last_data), 'h3C);
    ctrl = C_EN | C_D8;
    settle();
  endtask

  task automatic t_rx();
    int pu0, e0;
    ctrl = C_EN | C_D8;
    pu0 = n_push; e0 = n_perr + n_ferr + n_brk + n_ovf;
    send_rx('h96, 8, 0, 0, 1);
    chk(n_push == pu0 + 1 && last_data == 8'h96, "R9 8-bit receive", int'(last_data), 'h96);
    chk(n_perr + n_ferr + n_brk + n_ovf == e0, "R9 clean frame no errors", n_perr + n_ferr + n_brk + n_ovf - e0, 0);
    ctrl = C_EN;
    send_rx('h7F, 7, 0, 0, 1);
    chk(last_data == 8'h7F, "R9 7-bit receive", int'(last_data), 'h7F);
    pu0 = n_push;
    uart_rx = 1'b0; repeat (8) @(negedge clk);
    uart_rx = 1'b1; repeat (500) @(negedge clk);
    chk(n_push == pu0, "R8 glitch ignored", n_push - pu0, 0);
  endtask

  task automatic t_rx_errors();
    int pu0, p0, f0, b0, o0;
    ctrl = C_EN | C_D8 | C_PE | (1 << 4);
    p0 = n_perr; pu0 = n_push;
    send_rx('h5B, 8, 1, 0, 1);
    chk(n_perr == p0 + 1 && n_push == pu0 + 1, "R10 parity error flagged", n_perr - p0, 1);
    p0 = n_perr;
    send_rx('h5B, 8, 1, 1, 1);
    chk(n_perr == p0, "R10 good parity", n_perr - p0, 0);
    ctrl = C_EN | C_D8;
    f0 = n_ferr; b0 = n_brk;
    send_rx('h41, 8, 0, 0, 0);
    chk(n_ferr == f0 + 1, "R11 framing error", n_ferr - f0, 1);
    chk(n_brk == b0, "R11 no break for data", n_brk - b0, 0);
    f0 = n_ferr; b0 = n_brk; pu0 = n_push;
    uart_rx = 1'b0; repeat (32 * 14) @(negedge clk);
    uart_rx = 1'b1; repeat (300) @(negedge clk);
    chk(n_brk == b0 + 1 && n_ferr == f0 + 1, "R12 break flagged", n_brk - b0, 1);
    chk(n_push == pu0 + 1 && last_data == 8'h00, "R12 single char on break", n_push - pu0, 1);
    rx_full = 1'b1;
    o0 = n_ovf; pu0 = n_push;
    send_rx('h11, 8, 0, 0, 1);
    chk(n_ovf == o0 + 1, "R13 overflow flagged", n_ovf - o0, 1);
    chk(n_push == pu0, "R13 char dropped", n_push - pu0, 0);
    rx_full = 1'b0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    t_reset();
    t_tx_basic();
    t_tx_parity();
    t_stop2();
    t_flow();
    t_enable();
    t_loop();
    t_rx();
    t_rx_errors();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule